// File: doc/BRIEF.md
# Watermark-Driven DMA Request Controller

This block keeps a byte-level fill count for every channel of a receive buffer and of a transmit buffer. It decides, channel by channel, when a bus DMA engine should move data. It does not hold the data and does not speak the bus protocol. It only observes the byte counts entering and leaving each channel's region and raises per-channel request lines.

On the receive side, a channel requests a burst read once its level climbs strictly above a programmable high watermark. It also requests one as soon as a frame end has been stored. A frame end forces the request even when the level is small, and a separate flag reports that frame ends are pending. Once raised, the receive request stays up until the burst has emptied the region and retired every stored frame end, however many frames that spans.

On the transmit side, a channel requests a fill while its level is strictly below a programmable low watermark. It does so only while the DMA reports that the host has posted data for that channel. All counters and requests are registered and change on the clock edge that samples the causing input.

Top module: `wmdc_top`

## Requirements
- R1: A receive push adds its byte count to the channel level. `rx_req[i]` rises on the edge where the level becomes strictly greater than `rx_hwm`. A level equal to `rx_hwm` alone does not raise it.
- R2: Once set, `rx_req[i]` stays asserted until the channel level is zero and no stored frame end remains. It clears on the edge where both become true.
- R3: A receive push with `rx_push_eof` set stores one frame end. While any frame end is stored, both `rx_req[i]` and `rx_req_eof[i]` are 1 at any level. A receive pop with `rx_pop_eof` set retires one frame end.
- R4: Up to 2^EOF_W-1 stored frame ends per channel are counted. The request and the EOF flag persist until the last one is retired.
- R5: `tx_req[i]` is 1 after an edge at which `tx_data_avail[i]` was 1 and the new transmit level is strictly below `tx_lwm`. It drops on the edge where the level reaches `tx_lwm`.
- R6: `tx_req[i]` drops on the edge that samples `tx_data_avail[i]` low, at any level.
- R7: Levels saturate at 0 and at 2^LVL_W-1. A pop from an empty channel leaves it at 0. Pushes beyond full hold it at full, with no wrap-around.
- R8: A push and a pop on the same channel in one cycle change the level by their difference.
- R9: While `rst_n` is low, every level, frame-end count and request is cleared, and all outputs read 0.
- R10: A change of `rx_hwm` takes effect on the next edge with no data movement. Only the addressed channel (`*_ch`) is affected by a push or pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_hwm | input | LVL_W | Receive high watermark in bytes |
| tx_lwm | input | LVL_W | Transmit low watermark in bytes |
| rx_push_en | input | 1 | Bytes stored into a receive region |
| rx_push_ch | input | CH_W | Channel of the receive push |
| rx_push_bytes | input | BYTES_W | Byte count of the receive push |
| rx_push_eof | input | 1 | The receive push ends a frame |
| rx_pop_en | input | 1 | Bytes burst-read out of a receive region |
| rx_pop_ch | input | CH_W | Channel of the receive pop |
| rx_pop_bytes | input | BYTES_W | Byte count of the receive pop |
| rx_pop_eof | input | 1 | The receive pop passes one frame end |
| tx_push_en | input | 1 | Bytes filled into a transmit region by DMA |
| tx_push_ch | input | CH_W | Channel of the transmit push |
| tx_push_bytes | input | BYTES_W | Byte count of the transmit push |
| tx_pop_en | input | 1 | Bytes taken from a transmit region |
| tx_pop_ch | input | CH_W | Channel of the transmit pop |
| tx_pop_bytes | input | BYTES_W | Byte count of the transmit pop |
| tx_data_avail | input | NCH | Host has posted transmit data, per channel |
| rx_req | output | NCH | Receive burst-read request, per channel |
| rx_req_eof | output | NCH | Frame end pending in the receive region |
| tx_req | output | NCH | Transmit fill request, per channel |

## Verification
Several properties are checked on every cycle by the embedded assertions:
- the receive request holds until the region is empty and free of frame ends;
- a stored frame end always forces the request;
- a level above the watermark always shows a request;
- a transmit request implies a level below the low watermark and an available flag in the previous cycle;
- a pure push never lowers a level and a pure pop never raises it.

Some behaviour only the bench scenarios can show. Examples are the exact edge on which a threshold is crossed (equal versus above) and the net result of a simultaneous push and pop. Others are the saturation points seen through when a request finally clears, the counting of several queued frames, and the effect of reprogramming a watermark.

// File: rtl/wmdc_pkg.sv
package wmdc_pkg;
  localparam int unsigned WMDC_NCH     = 4;
  localparam int unsigned WMDC_LVL_W   = 8;
  localparam int unsigned WMDC_BYTES_W = 4;
  localparam int unsigned WMDC_EOF_W   = 3;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_DEC  = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/wmdc_level_ctr.sv
module wmdc_level_ctr #(
  parameter int unsigned LVL_W   = wmdc_pkg::WMDC_LVL_W,
  parameter int unsigned BYTES_W = wmdc_pkg::WMDC_BYTES_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               add_en,
  input  logic [BYTES_W-1:0] add_amt,
  input  logic               sub_en,
  input  logic [BYTES_W-1:0] sub_amt,
  output logic [LVL_W-1:0]   lvl_q,
  output logic [LVL_W-1:0]   lvl_nxt
);
  localparam int unsigned SUM_W = LVL_W + 2;
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  logic [SUM_W-1:0] add_ext, sub_ext, sum;
  logic             upd_en;

  assign upd_en = add_en | sub_en;

  always_comb begin
    add_ext = add_en ? SUM_W'(add_amt) : '0;
    sub_ext = sub_en ? SUM_W'(sub_amt) : '0;
    sum     = SUM_W'(lvl_q) + add_ext - sub_ext;
    if (sum[SUM_W-1]) begin
      lvl_nxt = '0;
    end else if (sum > SUM_W'(LVL_MAX)) begin
      lvl_nxt = LVL_MAX;
    end else begin
      lvl_nxt = sum[LVL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (upd_en) begin
      lvl_q <= lvl_nxt;
    end
  end

  // R7: pure pushes never lower the level, pure pops never raise it
  assert_push_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en && !sub_en) |=> (lvl_q >= $past(lvl_q)));
  assert_pop_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_en && !add_en) |=> (lvl_q <= $past(lvl_q)));
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(add_en || sub_en) |=> $stable(lvl_q));
endmodule

// File: rtl/wmdc_rx_chan.sv
module wmdc_rx_chan #(
  parameter int unsigned LVL_W   = wmdc_pkg::WMDC_LVL_W,
  parameter int unsigned BYTES_W = wmdc_pkg::WMDC_BYTES_W,
  parameter int unsigned EOF_W   = wmdc_pkg::WMDC_EOF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LVL_W-1:0]   hwm,
  input  logic               push_en,
  input  logic [BYTES_W-1:0] push_bytes,
  input  logic               push_eof,
  input  logic               pop_en,
  input  logic [BYTES_W-1:0] pop_bytes,
  input  logic               pop_eof,
  output logic               req,
  output logic               req_eof
);
  import wmdc_pkg::*;

  localparam logic [EOF_W-1:0] EOF_MAX = '1;

  logic [LVL_W-1:0] lvl_q, lvl_nxt;
  logic [EOF_W-1:0] eof_q, eof_nxt;
  logic             eof_upd;
  cnt_op_e          eof_op;
  logic             req_q, req_nxt;

  wmdc_level_ctr #(.LVL_W(LVL_W), .BYTES_W(BYTES_W)) u_lvl (
    .clk     (clk),
    .rst_n   (rst_n),
    .add_en  (push_en),
    .add_amt (push_bytes),
    .sub_en  (pop_en),
    .sub_amt (pop_bytes),
    .lvl_q   (lvl_q),
    .lvl_nxt (lvl_nxt)
  );

  // frame-end bookkeeping: next state
  always_comb begin
    eof_op = CNT_HOLD;
    if ((push_en && push_eof) && !(pop_en && pop_eof) && (eof_q != EOF_MAX)) begin
      eof_op = CNT_INC;
    end else if ((pop_en && pop_eof) && !(push_en && push_eof) && (eof_q != '0)) begin
      eof_op = CNT_DEC;
    end
    unique case (eof_op)
      CNT_INC: eof_nxt = eof_q + 1'b1;
      CNT_DEC: eof_nxt = eof_q - 1'b1;
      default: eof_nxt = eof_q;
    endcase
    eof_upd = (eof_op != CNT_HOLD);
  end

  // request: next state
  always_comb begin
    req_nxt = (lvl_nxt > hwm) || (eof_nxt != '0) || (req_q && (lvl_nxt != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eof_q <= '0;
    end else if (eof_upd) begin
      eof_q <= eof_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_nxt;
    end
  end

  assign req     = req_q;
  assign req_eof = (eof_q != '0);

  assert_hold_until_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> (req_q || ((lvl_q == '0) && (eof_q == '0))));
  assert_eof_forces_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_q != '0) |-> req_q);
  assert_above_hwm_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q > $past(hwm)) |-> req_q);
  assert_eof_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((eof_q == EOF_MAX) && push_en && push_eof && !(pop_en && pop_eof)) |=> (eof_q == EOF_MAX));
endmodule

// File: rtl/wmdc_tx_chan.sv
module wmdc_tx_chan #(
  parameter int unsigned LVL_W   = wmdc_pkg::WMDC_LVL_W,
  parameter int unsigned BYTES_W = wmdc_pkg::WMDC_BYTES_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LVL_W-1:0]   lwm,
  input  logic               push_en,
  input  logic [BYTES_W-1:0] push_bytes,
  input  logic               pop_en,
  input  logic [BYTES_W-1:0] pop_bytes,
  input  logic               avail,
  output logic               req
);
  logic [LVL_W-1:0] lvl_q, lvl_nxt;
  logic             req_q, req_nxt;

  wmdc_level_ctr #(.LVL_W(LVL_W), .BYTES_W(BYTES_W)) u_lvl (
    .clk     (clk),
    .rst_n   (rst_n),
    .add_en  (push_en),
    .add_amt (push_bytes),
    .sub_en  (pop_en),
    .sub_amt (pop_bytes),
    .lvl_q   (lvl_q),
    .lvl_nxt (lvl_nxt)
  );

  always_comb begin
    req_nxt = avail && (lvl_nxt < lwm);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_nxt;
    end
  end

  assign req = req_q;

  assert_needs_avail_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !avail |=> !req_q);
  assert_below_lwm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (lvl_q < $past(lwm)));
endmodule

// File: rtl/wmdc_top.sv
module wmdc_top #(
  parameter int unsigned NCH     = wmdc_pkg::WMDC_NCH,
  parameter int unsigned LVL_W   = wmdc_pkg::WMDC_LVL_W,
  parameter int unsigned BYTES_W = wmdc_pkg::WMDC_BYTES_W,
  parameter int unsigned EOF_W   = wmdc_pkg::WMDC_EOF_W,
  localparam int unsigned CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LVL_W-1:0]   rx_hwm,
  input  logic [LVL_W-1:0]   tx_lwm,
  input  logic               rx_push_en,
  input  logic [CH_W-1:0]    rx_push_ch,
  input  logic [BYTES_W-1:0] rx_push_bytes,
  input  logic               rx_push_eof,
  input  logic               rx_pop_en,
  input  logic [CH_W-1:0]    rx_pop_ch,
  input  logic [BYTES_W-1:0] rx_pop_bytes,
  input  logic               rx_pop_eof,
  input  logic               tx_push_en,
  input  logic [CH_W-1:0]    tx_push_ch,
  input  logic [BYTES_W-1:0] tx_push_bytes,
  input  logic               tx_pop_en,
  input  logic [CH_W-1:0]    tx_pop_ch,
  input  logic [BYTES_W-1:0] tx_pop_bytes,
  input  logic [NCH-1:0]     tx_data_avail,
  output logic [NCH-1:0]     rx_req,
  output logic [NCH-1:0]     rx_req_eof,
  output logic [NCH-1:0]     tx_req
);
  logic [NCH-1:0] rx_push_hit, rx_pop_hit, tx_push_hit, tx_pop_hit;

  for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
    assign rx_push_hit[gi] = rx_push_en && (rx_push_ch == CH_W'(gi));
    assign rx_pop_hit[gi]  = rx_pop_en  && (rx_pop_ch  == CH_W'(gi));
    assign tx_push_hit[gi] = tx_push_en && (tx_push_ch == CH_W'(gi));
    assign tx_pop_hit[gi]  = tx_pop_en  && (tx_pop_ch  == CH_W'(gi));

    wmdc_rx_chan #(.LVL_W(LVL_W), .BYTES_W(BYTES_W), .EOF_W(EOF_W)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .hwm        (rx_hwm),
      .push_en    (rx_push_hit[gi]),
      .push_bytes (rx_push_bytes),
      .push_eof   (rx_push_eof),
      .pop_en     (rx_pop_hit[gi]),
      .pop_bytes  (rx_pop_bytes),
      .pop_eof    (rx_pop_eof),
      .req        (rx_req[gi]),
      .req_eof    (rx_req_eof[gi])
    );

    wmdc_tx_chan #(.LVL_W(LVL_W), .BYTES_W(BYTES_W)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .lwm        (tx_lwm),
      .push_en    (tx_push_hit[gi]),
      .push_bytes (tx_push_bytes),
      .pop_en     (tx_pop_hit[gi]),
      .pop_bytes  (tx_pop_bytes),
      .avail      (tx_data_avail[gi]),
      .req        (tx_req[gi])
    );
  end

  // R3: the frame-end flag never shows without the request
  assert_eof_flag_in_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_req_eof & ~rx_req) == '0));
  // R6: no transmit request on a channel whose availability was low
  assert_tx_req_subset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_req & ~$past(tx_data_avail)) == '0));
endmodule

// File: tb/wmdc_tb.sv
module wmdc_top_tb_top;
  localparam int CLK_P = 10;
  localparam int NCH = 4, LVL_W = 8, BYTES_W = 4, EOF_W = 3, CH_W = 2;
  localparam int WD_CYCLES = 20000;

  // op: 0 idle, 1 rx push, 2 rx pop, 3 tx push, 4 tx pop; flg = eof mark
  typedef struct packed {
    logic [2:0] op;
    logic [1:0] ch;
    logic [3:0] nb;
    logic       flg;
    logic [3:0] av;
    logic [3:0] erx;
    logic [3:0] eeof;
    logic [3:0] etx;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VT [NV] = '{
    '{3'd1, 2'd0, 4'd8,  1'b0, 4'h0, 4'h0, 4'h0, 4'h0}, // R1 below
    '{3'd1, 2'd0, 4'd3,  1'b0, 4'h0, 4'h1, 4'h0, 4'h0}, // R1 above (11)
    '{3'd2, 2'd0, 4'd5,  1'b0, 4'h0, 4'h1, 4'h0, 4'h0}, // R2 hold
    '{3'd2, 2'd0, 4'd6,  1'b0, 4'h0, 4'h0, 4'h0, 4'h0}, // R2 empty
    '{3'd1, 2'd1, 4'd2,  1'b1, 4'h0, 4'h2, 4'h2, 4'h0}, // R3 eof
    '{3'd1, 2'd1, 4'd3,  1'b1, 4'h0, 4'h2, 4'h2, 4'h0}, // R4 two eofs
    '{3'd2, 2'd1, 4'd5,  1'b1, 4'h0, 4'h2, 4'h2, 4'h0}, // R4 one left
    '{3'd2, 2'd1, 4'd0,  1'b1, 4'h0, 4'h0, 4'h0, 4'h0}, // R3 retire
    '{3'd1, 2'd2, 4'd10, 1'b0, 4'h0, 4'h0, 4'h0, 4'h0}, // R1 equal
    '{3'd1, 2'd2, 4'd1,  1'b0, 4'h0, 4'h4, 4'h0, 4'h0}, // R1 / R10 ch2 only
    '{3'd0, 2'd0, 4'd0,  1'b0, 4'h1, 4'h4, 4'h0, 4'h1}, // R5
    '{3'd3, 2'd0, 4'd5,  1'b0, 4'h1, 4'h4, 4'h0, 4'h1}, // R5 level 5
    '{3'd3, 2'd0, 4'd1,  1'b0, 4'h1, 4'h4, 4'h0, 4'h0}, // R5 reaches lwm
    '{3'd4, 2'd0, 4'd1,  1'b0, 4'h1, 4'h4, 4'h0, 4'h1}, // R5 below again
    '{3'd0, 2'd0, 4'd0,  1'b0, 4'h0, 4'h4, 4'h0, 4'h0}, // R6
    '{3'd0, 2'd0, 4'd0,  1'b0, 4'h8, 4'h4, 4'h0, 4'h8}, // R5 ch3
    '{3'd2, 2'd2, 4'd11, 1'b0, 4'h8, 4'h0, 4'h0, 4'h8}  // R2 drain
  };

  logic clk, rst_n;
  logic [LVL_W-1:0] rx_hwm, tx_lwm;
  logic rx_push_en, rx_push_eof, rx_pop_en, rx_pop_eof, tx_push_en, tx_pop_en;
  logic [CH_W-1:0] rx_push_ch, rx_pop_ch, tx_push_ch, tx_pop_ch;
  logic [BYTES_W-1:0] rx_push_bytes, rx_pop_bytes, tx_push_bytes, tx_pop_bytes;
  logic [NCH-1:0] tx_data_avail, rx_req, rx_req_eof, tx_req;

  int n_vec, n_bad;
  logic done;

  wmdc_top #(.NCH(NCH), .LVL_W(LVL_W), .BYTES_W(BYTES_W), .EOF_W(EOF_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_hwm(rx_hwm), .tx_lwm(tx_lwm),
    .rx_push_en(rx_push_en), .rx_push_ch(rx_push_ch), .rx_push_bytes(rx_push_bytes),
    .rx_push_eof(rx_push_eof), .rx_pop_en(rx_pop_en), .rx_pop_ch(rx_pop_ch),
    .rx_pop_bytes(rx_pop_bytes), .rx_pop_eof(rx_pop_eof),
    .tx_push_en(tx_push_en), .tx_push_ch(tx_push_ch), .tx_push_bytes(tx_push_bytes),
    .tx_pop_en(tx_pop_en), .tx_pop_ch(tx_pop_ch), .tx_pop_bytes(tx_pop_bytes),
    .tx_data_avail(tx_data_avail), .rx_req(rx_req), .rx_req_eof(rx_req_eof),
    .tx_req(tx_req)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic idle_inputs();
    rx_push_en = 0; rx_push_ch = '0; rx_push_bytes = '0; rx_push_eof = 0;
    rx_pop_en = 0;  rx_pop_ch = '0;  rx_pop_bytes = '0;  rx_pop_eof = 0;
    tx_push_en = 0; tx_push_ch = '0; tx_push_bytes = '0;
    tx_pop_en = 0;  tx_pop_ch = '0;  tx_pop_bytes = '0;
  endtask

  task automatic set_op(input logic [2:0] op, input logic [1:0] ch,
                        input logic [3:0] nb, input logic flg);
    case (op)
      3'd1: begin rx_push_en = 1; rx_push_ch = ch; rx_push_bytes = nb; rx_push_eof = flg; end
      3'd2: begin rx_pop_en = 1;  rx_pop_ch = ch;  rx_pop_bytes = nb;  rx_pop_eof = flg;  end
      3'd3: begin tx_push_en = 1; tx_push_ch = ch; tx_push_bytes = nb; end
      3'd4: begin tx_pop_en = 1;  tx_pop_ch = ch;  tx_pop_bytes = nb;  end
      default: ;
    endcase
  endtask

  // drive at the falling edge, let one rising edge act, then settle
  task automatic step(input logic [2:0] op, input logic [1:0] ch,
                      input logic [3:0] nb, input logic flg);
    @(negedge clk);
    idle_inputs();
    set_op(op, ch, nb, flg);
    @(posedge clk);
    #1;
    idle_inputs();
    #(CLK_P/4);
  endtask

  task automatic chk(input string rq, input logic [3:0] erx,
                     input logic [3:0] eeof, input logic [3:0] etx);
    n_vec++;
    if (rx_req !== erx || rx_req_eof !== eeof || tx_req !== etx) begin
      n_bad++;
      $display("FAIL %s: rx_req=%b rx_req_eof=%b tx_req=%b expected %b %b %b",
               rq, rx_req, rx_req_eof, tx_req, erx, eeof, etx);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; done = 0;
    idle_inputs();
    tx_data_avail = '0;
    rx_hwm = 8'd10; tx_lwm = 8'd6;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    chk("R9 reset state", 4'h0, 4'h0, 4'h0);
    @(negedge clk) rst_n = 1;

    // table walk
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      tx_data_avail = VT[v].av;
      step(VT[v].op, VT[v].ch, VT[v].nb, VT[v].flg);
      chk($sformatf("table vector %0d (R1..R6 per row)", v), VT[v].erx, VT[v].eeof, VT[v].etx);
    end

    // R9: reset clears active requests
    @(negedge clk) tx_data_avail = 4'hF;
    step(3'd1, 2'd0, 4'd12, 1'b0);
    chk("R9 pre-reset activity", 4'h1, 4'h0, 4'hF);
    @(negedge clk) begin rst_n = 0; tx_data_avail = '0; end
    #(CLK_P/4);
    chk("R9 async clear", 4'h0, 4'h0, 4'h0);
    @(negedge clk) rst_n = 1;

    // R7: saturation at full
    for (int k = 0; k < 20; k++) step(3'd1, 2'd3, 4'd15, 1'b0);
    chk("R7 fill past full", 4'h8, 4'h0, 4'h0);
    for (int k = 0; k < 16; k++) step(3'd2, 2'd3, 4'd15, 1'b0);
    chk("R7 held at full, 15 left", 4'h8, 4'h0, 4'h0);
    step(3'd2, 2'd3, 4'd15, 1'b0);
    chk("R7 drained from full", 4'h0, 4'h0, 4'h0);

    // R7: pop from empty stays at zero
    step(3'd2, 2'd0, 4'd5, 1'b0);
    chk("R7 pop on empty", 4'h0, 4'h0, 4'h0);
    step(3'd1, 2'd0, 4'd10, 1'b0);
    chk("R7 level exactly 10 after empty pop", 4'h0, 4'h0, 4'h0);

    // R8: simultaneous push and pop
    @(negedge clk);
    idle_inputs();
    rx_push_en = 1; rx_push_ch = 2'd1; rx_push_bytes = 4'd8;
    rx_pop_en = 1;  rx_pop_ch = 2'd1;  rx_pop_bytes = 4'd3;
    @(posedge clk); #1; idle_inputs(); #(CLK_P/4);
    chk("R8 net 5", 4'h0, 4'h0, 4'h0);
    step(3'd1, 2'd1, 4'd5, 1'b0);
    chk("R8 level 10", 4'h0, 4'h0, 4'h0);
    step(3'd1, 2'd1, 4'd1, 1'b0);
    chk("R8 level 11", 4'h2, 4'h0, 4'h0);

    // R10: watermark change alone raises request
    @(negedge clk) rx_hwm = 8'd9;
    @(posedge clk); #(CLK_P/4);
    chk("R10 hwm lowered", 4'h3, 4'h0, 4'h0);
    @(negedge clk) rx_hwm = 8'd10;

    // R4: three queued frames on ch2
    for (int k = 0; k < 3; k++) step(3'd1, 2'd2, 4'd1, 1'b1);
    chk("R4 three frames stored", 4'h7, 4'h4, 4'h0);
    step(3'd2, 2'd2, 4'd1, 1'b1);
    chk("R4 two frames left", 4'h7, 4'h4, 4'h0);
    step(3'd2, 2'd2, 4'd1, 1'b1);
    chk("R4 one frame left", 4'h7, 4'h4, 4'h0);
    step(3'd2, 2'd2, 4'd1, 1'b1);
    chk("R4 R3 all frames retired", 4'h3, 4'h0, 4'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule